// File: doc/BRIEF.md
# Floating-Point Issue Interlock

This block sits at the issue stage of an in-order pipeline that dispatches floating-point operations to execution units of unequal depth. Each cycle it looks at one candidate operation (its class, destination register and two source registers) and decides, combinationally, whether that operation may leave the issue stage in the current cycle. When it may not, it raises a stall flag and reports one cause code. Because issue is in order, the stalled candidate is simply presented again on the next cycle, and everything behind it waits.

The block keeps three kinds of timing state. The first is a countdown per execution unit that enforces the unit's minimum spacing between starts. The second is a bitmap of future write-back cycles that guards the single result write port. The third is a countdown per architectural register that gives the number of cycles until its newest pending result is written. Together these detect a busy unit, a write-port collision, a read of a result that is not ready, and an out-of-order overwrite caused by a short operation finishing ahead of a long one. The arithmetic itself is performed elsewhere.

Top module: `fp_issue_interlock`

## Requirements
- R1: Operation classes are coded as 0 add/subtract (latency 4, start spacing 3), 1 multiply (8, 4), 2 divide (36, 35), 3 square root (112, 111), 4 negate/absolute (2, 1), 5 compare (3, 2); codes 6 and 7 behave as code 0. A candidate issues in a cycle where `candValid` is high and `issueStall` is low; its result is written back exactly latency cycles after that cycle.
- R2: While `candValid` is low, `issueStall` is 0 and `stallCause` is 0 (none), whatever hazards exist.
- R3: After an operation issues, a candidate of the same class stalls with cause 1 (unit busy) for spacing-1 cycles and may issue on the cycle that is spacing cycles later; an operation of a different class is not held back by it.
- R4: A candidate whose write-back cycle equals the write-back cycle of an operation already issued stalls with cause 4 (write port); one cycle later the same candidate no longer collides.
- R5: A candidate reading (either source) a register that has a pending result stalls with cause 2 (read-after-write) until the cycle in which that result is written back, where it may issue.
- R6: A candidate whose destination has a pending result that would be written after the candidate's own write-back stalls with cause 3 (write-after-write).
- R7: A destination whose pending result finishes before the candidate's does not stall it; afterwards read hazards on that register follow the later writer.
- R8: When several hazards hold at once, the reported cause follows the order unit busy, then read-after-write, then write-after-write, then write port.
- R9: A stalled candidate reserves nothing: it claims no unit, no write-back cycle and no destination.
- R10: Reset (`rstN` low) clears all timing state, so after reset no candidate is held back by operations issued before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| candValid | input | 1 | A candidate operation is present |
| candOp | input | 3 | Operation class code (R1) |
| candDst | input | 5 | Destination register |
| candSrcA | input | 5 | First source register |
| candSrcB | input | 5 | Second source register |
| issueStall | output | 1 | Candidate must stay in the issue stage this cycle |
| stallCause | output | 3 | 0 none, 1 unit busy, 2 read-after-write, 3 write-after-write, 4 write port |

## Verification
Back-to-back operations of every class are presented to measure each unit's start spacing exactly, which separates a timer that is one cycle short or long from a correct one. A long operation is followed by a shorter one aimed at the same write-back cycle, a reader of its result, and a short writer of its destination, and each is held until the first cycle it may go, which tells the three countdown mechanisms apart. Candidates that carry several hazards at once fix the cause priority. A stalled candidate followed by operations that would collide only with its phantom reservation shows that stalling leaves no trace, and a reset in the middle of a long operation shows that the state is cleared.

// File: rtl/fpi_pkg.sv
package fpi_pkg;

  localparam int OP_W     = 3;
  localparam int REG_W    = 5;
  localparam int NUM_REGS = 1 << REG_W;
  localparam int NUM_UNITS = 6;
  localparam int UNIT_W   = $clog2(NUM_UNITS);

  localparam int LAT_ADD  = 4;
  localparam int LAT_MUL  = 8;
  localparam int LAT_DIV  = 36;
  localparam int LAT_SQRT = 112;
  localparam int LAT_NEG  = 2;
  localparam int LAT_CMP  = 3;

  localparam int GAP_ADD  = 3;
  localparam int GAP_MUL  = 4;
  localparam int GAP_DIV  = 35;
  localparam int GAP_SQRT = 111;
  localparam int GAP_NEG  = 1;
  localparam int GAP_CMP  = 2;

  localparam int MAX_LAT  = LAT_SQRT;
  localparam int CNT_W    = $clog2(MAX_LAT + 1);
  localparam int SLOT_N   = MAX_LAT + 1;

  typedef enum logic [2:0] {
    CAUSE_NONE = 3'd0,
    CAUSE_UNIT = 3'd1,
    CAUSE_RAW  = 3'd2,
    CAUSE_WAW  = 3'd3,
    CAUSE_PORT = 3'd4
  } cause_e;

  typedef struct packed {
    logic              fire;
    logic [UNIT_W-1:0] unit;
    logic [REG_W-1:0]  dst;
    logic [CNT_W-1:0]  lat;
    logic [CNT_W-1:0]  gap;
  } issueStrobe_t;

  function automatic logic [UNIT_W-1:0] opUnit(input logic [OP_W-1:0] op);
    case (op)
      3'd1:    return UNIT_W'(1);
      3'd2:    return UNIT_W'(2);
      3'd3:    return UNIT_W'(3);
      3'd4:    return UNIT_W'(4);
      3'd5:    return UNIT_W'(5);
      default: return UNIT_W'(0);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] opLatency(input logic [OP_W-1:0] op);
    case (op)
      3'd1:    return CNT_W'(LAT_MUL);
      3'd2:    return CNT_W'(LAT_DIV);
      3'd3:    return CNT_W'(LAT_SQRT);
      3'd4:    return CNT_W'(LAT_NEG);
      3'd5:    return CNT_W'(LAT_CMP);
      default: return CNT_W'(LAT_ADD);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] opSpacing(input logic [OP_W-1:0] op);
    case (op)
      3'd1:    return CNT_W'(GAP_MUL);
      3'd2:    return CNT_W'(GAP_DIV);
      3'd3:    return CNT_W'(GAP_SQRT);
      3'd4:    return CNT_W'(GAP_NEG);
      3'd5:    return CNT_W'(GAP_CMP);
      default: return CNT_W'(GAP_ADD);
    endcase
  endfunction

endpackage

// File: rtl/fpi_datapath.sv
module fpi_datapath
  import fpi_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  issueStrobe_t        strobe,
  input  logic [REG_W-1:0]    queryDst,
  input  logic [REG_W-1:0]    querySrcA,
  input  logic [REG_W-1:0]    querySrcB,
  output logic [NUM_UNITS-1:0] unitBusy,
  output logic [SLOT_N-1:0]   slotMap,
  output logic [CNT_W-1:0]    remDst,
  output logic [CNT_W-1:0]    remSrcA,
  output logic [CNT_W-1:0]    remSrcB
);

  // Per-unit start spacing timers
  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    logic [CNT_W-1:0] gapCnt;
    logic             loadHere;
    assign loadHere = strobe.fire && (strobe.unit == UNIT_W'(u));
    always_ff @(posedge clk) begin
      if (!rstN)               gapCnt <= '0;
      else if (loadHere)       gapCnt <= strobe.gap - 1'b1;
      else if (gapCnt != '0)   gapCnt <= gapCnt - 1'b1;
    end
    assign unitBusy[u] = (gapCnt != '0);
  end

  // Write-back cycle bitmap: bit k means a result is written k cycles from now
  logic [SLOT_N-1:0] slotNext;
  always_comb begin
    slotNext = slotMap >> 1;
    if (strobe.fire) slotNext[strobe.lat - 1'b1] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) slotMap <= '0;
    else       slotMap <= slotNext;
  end

  // Per-register countdown to the newest pending write-back
  logic [NUM_REGS-1:0][CNT_W-1:0] remCnt;
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic [CNT_W-1:0] cnt;
    logic             claim;
    assign claim = strobe.fire && (strobe.dst == REG_W'(r));
    always_ff @(posedge clk) begin
      if (!rstN)            cnt <= '0;
      else if (claim)       cnt <= strobe.lat - 1'b1;
      else if (cnt != '0)   cnt <= cnt - 1'b1;
    end
    assign remCnt[r] = cnt;
  end

  assign remDst  = remCnt[queryDst];
  assign remSrcA = remCnt[querySrcA];
  assign remSrcB = remCnt[querySrcB];

  // R4: an issued operation owns its write-back cycle on the following cycle
  assert_slot_claimed_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fire |=> slotMap[$past(strobe.lat) - 1'b1]);

  // R4: control never issues into a write-back cycle already taken
  assert_no_double_book_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fire |-> !slotMap[strobe.lat]);

  // R3: control never starts a unit whose spacing timer is running
  assert_unit_free_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fire |-> !unitBusy[strobe.unit]);

  // R6: an issued write never lands before an older pending write to the same register
  assert_no_waw_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fire |-> (remCnt[strobe.dst] < strobe.lat));

  // R9: without an issue the bitmap only ages
  assert_idle_ages_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.fire |=> (slotMap == ($past(slotMap) >> 1)));

endmodule

// File: rtl/fpi_control.sv
module fpi_control
  import fpi_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 candValid,
  input  logic [OP_W-1:0]      candOp,
  input  logic [REG_W-1:0]     candDst,
  input  logic [NUM_UNITS-1:0] unitBusy,
  input  logic [SLOT_N-1:0]    slotMap,
  input  logic [CNT_W-1:0]     remDst,
  input  logic [CNT_W-1:0]     remSrcA,
  input  logic [CNT_W-1:0]     remSrcB,
  output logic                 issueStall,
  output cause_e               stallCause,
  output issueStrobe_t         strobe
);

  logic [UNIT_W-1:0] unitSel;
  logic [CNT_W-1:0]  latSel;
  logic [CNT_W-1:0]  gapSel;
  logic              hzUnit, hzRaw, hzWaw, hzPort;
  cause_e            causeRaw;

  assign unitSel = opUnit(candOp);
  assign latSel  = opLatency(candOp);
  assign gapSel  = opSpacing(candOp);

  assign hzUnit = unitBusy[unitSel];
  assign hzRaw  = (remSrcA != '0) || (remSrcB != '0);
  assign hzWaw  = (remDst > latSel);
  assign hzPort = slotMap[latSel];

  always_comb begin
    if (hzUnit)      causeRaw = CAUSE_UNIT;
    else if (hzRaw)  causeRaw = CAUSE_RAW;
    else if (hzWaw)  causeRaw = CAUSE_WAW;
    else if (hzPort) causeRaw = CAUSE_PORT;
    else             causeRaw = CAUSE_NONE;
  end

  assign stallCause = candValid ? causeRaw : CAUSE_NONE;
  assign issueStall = candValid && (causeRaw != CAUSE_NONE);

  always_comb begin
    strobe.fire = candValid && (causeRaw == CAUSE_NONE);
    strobe.unit = unitSel;
    strobe.dst  = candDst;
    strobe.lat  = latSel;
    strobe.gap  = gapSel;
  end

  // R2: an absent candidate never stalls
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    !candValid |-> (!issueStall && stallCause == CAUSE_NONE));

  // R5: an issued operation finds both sources ready
  assert_sources_ready_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fire |-> (remSrcA == '0 && remSrcB == '0));

  // R8: a stall always names exactly one cause
  assert_cause_named_R8: assert property (@(posedge clk) disable iff (!rstN)
    issueStall |-> (stallCause != CAUSE_NONE && !strobe.fire));

endmodule

// File: rtl/fp_issue_interlock.sv
module fp_issue_interlock
  import fpi_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             candValid,
  input  logic [2:0]       candOp,
  input  logic [4:0]       candDst,
  input  logic [4:0]       candSrcA,
  input  logic [4:0]       candSrcB,
  output logic             issueStall,
  output logic [2:0]       stallCause
);

  issueStrobe_t         strobe;
  logic [NUM_UNITS-1:0] unitBusy;
  logic [SLOT_N-1:0]    slotMap;
  logic [CNT_W-1:0]     remDst, remSrcA, remSrcB;
  cause_e               causeCode;

  fpi_control u_control (
    .clk        (clk),
    .rstN       (rstN),
    .candValid  (candValid),
    .candOp     (candOp),
    .candDst    (candDst),
    .unitBusy   (unitBusy),
    .slotMap    (slotMap),
    .remDst     (remDst),
    .remSrcA    (remSrcA),
    .remSrcB    (remSrcB),
    .issueStall (issueStall),
    .stallCause (causeCode),
    .strobe     (strobe)
  );

  fpi_datapath u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .queryDst  (candDst),
    .querySrcA (candSrcA),
    .querySrcB (candSrcB),
    .unitBusy  (unitBusy),
    .slotMap   (slotMap),
    .remDst    (remDst),
    .remSrcA   (remSrcA),
    .remSrcB   (remSrcB)
  );

  assign stallCause = causeCode;

endmodule

// File: tb/fp_issue_interlock_test.sv
`timescale 1ns/1ps
module fp_issue_interlock_test;

  localparam int PERIOD = 20;

  logic       clk = 1'b0;
  logic       rstN;
  logic       candValid;
  logic [2:0] candOp;
  logic [4:0] candDst, candSrcA, candSrcB;
  logic       issueStall;
  logic [2:0] stallCause;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  fp_issue_interlock uut (
    .clk(clk), .rstN(rstN), .candValid(candValid), .candOp(candOp),
    .candDst(candDst), .candSrcA(candSrcA), .candSrcB(candSrcB),
    .issueStall(issueStall), .stallCause(stallCause)
  );

  // Cause codes (R8 ordering, values from the port table)
  localparam logic [2:0] C_NONE = 3'd0, C_UNIT = 3'd1, C_RAW = 3'd2,
                         C_WAW = 3'd3, C_PORT = 3'd4;
  // Class codes (R1)
  localparam logic [2:0] K_ADD = 3'd0, K_MUL = 3'd1, K_DIV = 3'd2,
                         K_SQRT = 3'd3, K_NEG = 3'd4, K_CMP = 3'd5;

  // Drive one cycle's candidate at the falling edge, then settle
  task automatic present(input logic v, input logic [2:0] op, input logic [4:0] d,
                         input logic [4:0] a, input logic [4:0] b);
    @(negedge clk);
    candValid = v; candOp = op; candDst = d; candSrcA = a; candSrcB = b;
    #1;
  endtask

  task automatic expectOut(input logic expStall, input logic [2:0] expCause,
                           input string tag);
    checks++;
    if (issueStall !== expStall || stallCause !== expCause) begin
      errors++;
      $display("FAIL %s: stall=%0b cause=%0d expected stall=%0b cause=%0d",
               tag, issueStall, stallCause, expStall, expCause);
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 120; i++) present(1'b0, K_ADD, 5'd0, 5'd0, 5'd0);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; candValid = 1'b0; candOp = '0; candDst = '0; candSrcA = '0; candSrcB = '0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // R10: reset state and clearing of in-flight state
  task automatic testReset();
    present(1'b0, K_SQRT, 5'd1, 5'd2, 5'd3);
    expectOut(1'b0, C_NONE, "R10 reset idle");
    present(1'b1, K_DIV, 5'd5, 5'd2, 5'd3);
    expectOut(1'b0, C_NONE, "R10 first issue after reset");
    doReset();
    present(1'b1, K_DIV, 5'd6, 5'd5, 5'd5);
    expectOut(1'b0, C_NONE, "R10 reset clears pending reg and unit");
    drain();
  endtask

  // R1 R3: start spacing per class
  task automatic spacing(input logic [2:0] op, input int gap, input string tag);
    present(1'b1, op, 5'd10, 5'd20, 5'd21);
    expectOut(1'b0, C_NONE, {tag, " first start"});
    for (int k = 1; k < gap; k++) begin
      present(1'b1, op, 5'd11, 5'd22, 5'd23);
      expectOut(1'b1, C_UNIT, {tag, " held by spacing"});
    end
    present(1'b1, op, 5'd11, 5'd22, 5'd23);
    expectOut(1'b0, C_NONE, {tag, " spacing elapsed"});
    drain();
  endtask

  task automatic testSpacing();
    spacing(K_ADD,  3,   "R3 R1 add");
    spacing(K_MUL,  4,   "R3 R1 mul");
    spacing(K_DIV,  35,  "R3 R1 div");
    spacing(K_SQRT, 111, "R3 R1 sqrt");
    spacing(K_NEG,  1,   "R3 R1 neg");
    spacing(K_CMP,  2,   "R3 R1 cmp");
    spacing(3'd6,   3,   "R1 code6 as add");
    // R3: other unit not held
    present(1'b1, K_MUL, 5'd3, 5'd20, 5'd21);
    present(1'b1, K_ADD, 5'd4, 5'd28, 5'd29);
    expectOut(1'b0, C_NONE, "R3 other unit independent");
    drain();
  endtask

  // R4: write-port collision
  task automatic testPort();
    present(1'b1, K_MUL, 5'd1, 5'd20, 5'd21);
    for (int i = 0; i < 3; i++) present(1'b0, K_ADD, 5'd0, 5'd0, 5'd0);
    present(1'b1, K_ADD, 5'd2, 5'd22, 5'd23);
    expectOut(1'b1, C_PORT, "R4 same write-back cycle");
    present(1'b1, K_ADD, 5'd2, 5'd22, 5'd23);
    expectOut(1'b0, C_NONE, "R4 next cycle free");
    drain();
  endtask

  // R5 R2: read of a pending result
  task automatic testRaw();
    present(1'b1, K_DIV, 5'd5, 5'd20, 5'd21);
    present(1'b0, K_ADD, 5'd6, 5'd5, 5'd5);
    expectOut(1'b0, C_NONE, "R2 invalid candidate with hazard");
    for (int c = 2; c < 36; c++) begin
      present(1'b1, K_ADD, 5'd6, 5'd22, 5'd5);
      expectOut(1'b1, C_RAW, "R5 source B pending");
    end
    present(1'b1, K_ADD, 5'd6, 5'd22, 5'd5);
    expectOut(1'b0, C_NONE, "R5 result written back");
    drain();
    present(1'b1, K_CMP, 5'd7, 5'd20, 5'd21);
    present(1'b1, K_NEG, 5'd8, 5'd7, 5'd22);
    expectOut(1'b1, C_RAW, "R5 source A pending");
    present(1'b1, K_NEG, 5'd8, 5'd7, 5'd22);
    expectOut(1'b1, C_RAW, "R5 source A last pending cycle");
    present(1'b1, K_NEG, 5'd8, 5'd7, 5'd22);
    expectOut(1'b0, C_NONE, "R5 source A ready");
    drain();
  endtask

  // R6 R7: overwrite ordering
  task automatic testWaw();
    present(1'b1, K_MUL, 5'd7, 5'd20, 5'd21);
    for (int c = 1; c < 6; c++) begin
      present(1'b1, K_NEG, 5'd7, 5'd22, 5'd23);
      expectOut(1'b1, C_WAW, "R6 short write overtakes long");
    end
    present(1'b1, K_NEG, 5'd7, 5'd22, 5'd23);
    expectOut(1'b1, C_PORT, "R6 equal finish is port clash");
    present(1'b1, K_NEG, 5'd7, 5'd22, 5'd23);
    expectOut(1'b0, C_NONE, "R6 finishes after older write");
    drain();
    present(1'b1, K_NEG, 5'd8, 5'd20, 5'd21);
    present(1'b1, K_MUL, 5'd8, 5'd22, 5'd23);
    expectOut(1'b0, C_NONE, "R7 earlier-finishing writer allows issue");
    present(1'b1, K_ADD, 5'd9, 5'd8, 5'd24);
    expectOut(1'b1, C_RAW, "R7 reader waits for later writer");
    for (int c = 3; c < 9; c++) present(1'b1, K_ADD, 5'd9, 5'd8, 5'd24);
    expectOut(1'b1, C_RAW, "R7 still waiting one cycle before");
    present(1'b1, K_ADD, 5'd9, 5'd8, 5'd24);
    expectOut(1'b0, C_NONE, "R7 later writer done");
    drain();
  endtask

  // R8: cause priority
  task automatic testPriority();
    present(1'b1, K_MUL, 5'd9, 5'd20, 5'd21);
    present(1'b1, K_MUL, 5'd22, 5'd9, 5'd23);
    expectOut(1'b1, C_UNIT, "R8 unit over raw");
    drain();
    present(1'b1, K_DIV, 5'd10, 5'd20, 5'd21);
    present(1'b1, K_ADD, 5'd10, 5'd10, 5'd23);
    expectOut(1'b1, C_RAW, "R8 raw over waw");
    drain();
    present(1'b1, K_DIV, 5'd12, 5'd20, 5'd21);
    present(1'b1, K_MUL, 5'd13, 5'd22, 5'd23);
    expectOut(1'b0, C_NONE, "R8 setup mul issues");
    for (int i = 0; i < 3; i++) present(1'b0, K_ADD, 5'd0, 5'd0, 5'd0);
    present(1'b1, K_ADD, 5'd12, 5'd24, 5'd25);
    expectOut(1'b1, C_WAW, "R8 waw over port");
    drain();
  endtask

  // R9: a stalled candidate leaves no reservation
  task automatic testHeld();
    present(1'b1, K_MUL, 5'd15, 5'd20, 5'd21);
    present(1'b1, K_MUL, 5'd16, 5'd23, 5'd24);
    expectOut(1'b1, C_UNIT, "R9 setup stalled mul");
    present(1'b1, K_ADD, 5'd25, 5'd16, 5'd16);
    expectOut(1'b0, C_NONE, "R9 stalled dest not pending");
    present(1'b0, K_ADD, 5'd0, 5'd0, 5'd0);
    present(1'b0, K_ADD, 5'd0, 5'd0, 5'd0);
    present(1'b1, K_ADD, 5'd17, 5'd26, 5'd27);
    expectOut(1'b0, C_NONE, "R9 stalled slot not reserved");
    drain();
  endtask

  initial begin
    candValid = 1'b0; candOp = '0; candDst = '0; candSrcA = '0; candSrcB = '0;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testSpacing();
    testPort();
    testRaw();
    testWaw();
    testPriority();
    testHeld();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog all: actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule